// File: doc/BRIEF.md
# Legacy Segment Limit Checker

This block checks one memory access against the protection rules of the segment it goes through, for a processor running outside 64-bit mode. A request presents the linear address, the access size in bytes, the access kind (read, write or instruction fetch), and the segment's index, selector, base, limit and attribute bits. It also presents the code segment's default-size bit, the address-size override and the long-mode state. One clock later the block returns a verdict: the access passes, or it raises a general-protection fault whose error code is zero.

The offset into the segment is the linear address minus the base. It is cut to 16 or 32 bits according to the effective address size, and the last byte of the access is offset plus size minus one. That end offset is kept one bit wider than the address, so an access that runs past the top of the space is not wrapped. Expand-up data segments accept bytes at or below the limit. Expand-down data segments accept bytes strictly above it. When long mode is active and the code segment is a 64-bit one, no check is made and every access passes.

The control is a two-state machine. ST_IDLE means no response is pending. ST_RESP means a verdict is on the outputs for this cycle. The transitions are: IDLE_TO_RESP on a request, RESP_TO_RESP on a back-to-back request, and RESP_TO_IDLE when no request follows. Reset goes to ST_IDLE.

Top module: `seglim_checker`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and carries the verdict for that request's inputs. In that cycle exactly one of `rsp_pass` and `rsp_gp` is high. When `rsp_valid` is low, both are low.
- R2: When `lma_on` and `cs_long` are both 1, the request passes whatever its other inputs are. This holds even for a zero selector or an out-of-limit offset. If only one of the two is set, the checks still apply.
- R3: Outside the bypass, a selector of value zero gives a fault.
- R4: A write through a data segment whose `attr_wr` is 0 gives a fault. A write through one with `attr_wr` 1 that is inside its limit passes.
- R5: A read that is neither a write nor an instruction fetch, through a data segment whose `attr_rd` is 0, gives a fault. Writes and fetches through such a segment are not affected by `attr_rd`.
- R6: Data segments are those with `seg_idx` from 1 to 6 inclusive. For every other index, `attr_wr`, `attr_rd` and `attr_expdn` have no effect, and the segment is bounded as expand-up.
- R7: The effective address size is 16 bits when `cs_dflt32` equals `asz_ovr`, and 32 bits otherwise. In 16-bit mode the offset is (`lin_addr` - `seg_base`) modulo 2^16.
- R8: For expand-up, a fault is raised when the offset or the end offset (offset + `acc_size` - 1) is greater than `seg_limit`. The end offset is computed without truncation.
- R9: For an expand-down data segment, a fault is raised when the offset or the end offset is less than or equal to `seg_limit`.
- R10: After reset, `rsp_valid`, `rsp_pass` and `rsp_gp` are 0. `rsp_err_code` is 0 on every fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| lin_addr | input | 32 | Effective linear address |
| acc_size | input | 4 | Access size in bytes, 1 or more |
| is_write | input | 1 | Access is a write |
| is_exec | input | 1 | Access is an instruction fetch |
| seg_idx | input | 4 | Segment index; 1 to 6 are data segments |
| seg_sel | input | 16 | Segment selector value |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit |
| attr_wr | input | 1 | Segment is writable |
| attr_rd | input | 1 | Segment is readable |
| attr_expdn | input | 1 | Segment is expand-down |
| cs_dflt32 | input | 1 | Code segment default size is 32 bits |
| cs_long | input | 1 | Code segment is a 64-bit segment |
| lma_on | input | 1 | Long mode is active |
| asz_ovr | input | 1 | Address-size override present |
| rsp_valid | output | 1 | Verdict is valid |
| rsp_pass | output | 1 | Access allowed |
| rsp_gp | output | 1 | General-protection fault |
| rsp_err_code | output | 16 | Fault error code, always zero |

## Verification
The assertions assume that `acc_size` is never zero when a request is made. A zero size would make the end offset fall one below the offset, and the ordering check would have no meaning. They also assume that reset is held for at least one clock before the first request. Every vector in the bench uses sizes of 1, 2 or 4 bytes. Inputs change only on the falling edge, with reset released before the first request, so each clocked property sees settled values.

// File: rtl/seglim_pkg.sv
package seglim_pkg;

    // Response state of the checker
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } seglim_state_e;

    // Intermediate findings gathered before the verdict is taken
    typedef struct packed {
        logic bypass;
        logic null_sel;
        logic rights;
        logic bound;
    } seglim_find_t;

endpackage

// File: rtl/seglim_offset.sv
module seglim_offset #(
    parameter int AW  = 32,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  lin_addr,
    input  logic [AW-1:0]  seg_base,
    input  logic [SZW-1:0] acc_size,
    input  logic           use16,
    output logic [AW:0]    off_x,
    output logic [AW:0]    end_x
);
    localparam int PADW = AW + 1 - SZW;

    logic [AW-1:0] diff;
    logic [AW-1:0] off_cut;

    assign diff = lin_addr - seg_base;

    generate
        if (AW > 16) begin : g_wide
            assign off_cut = use16 ? {{(AW-16){1'b0}}, diff[15:0]} : diff;
        end else begin : g_narrow
            logic unused_sel;
            assign unused_sel = use16;
            assign off_cut    = diff;
        end
    endgenerate

    assign off_x = {1'b0, off_cut};
    assign end_x = off_x + {{PADW{1'b0}}, acc_size} - {{AW{1'b0}}, 1'b1};

    always_comb begin
        // R8
        if (acc_size != '0) begin
            end_order_chk: assert (end_x >= off_x);
        end
    end
endmodule

// File: rtl/seglim_rights.sv
module seglim_rights #(
    parameter int IDXW = 4,
    parameter int SELW = 16,
    parameter int DLO  = 1,
    parameter int DHI  = 6
) (
    input  logic [IDXW-1:0] seg_idx,
    input  logic [SELW-1:0] seg_sel,
    input  logic            is_write,
    input  logic            is_exec,
    input  logic            attr_wr,
    input  logic            attr_rd,
    input  logic            attr_expdn,
    output logic            null_sel,
    output logic            rights_fault,
    output logic            use_expdn
);
    logic in_data;
    logic wr_bad;
    logic rd_bad;

    assign in_data = (seg_idx >= IDXW'(DLO)) && (seg_idx <= IDXW'(DHI));
    assign null_sel = (seg_sel == '0);

    always_comb begin
        wr_bad = is_write && !attr_wr;
        rd_bad = !is_write && !is_exec && !attr_rd;
        rights_fault = in_data && (wr_bad || rd_bad);
        use_expdn    = in_data && attr_expdn;
    end

    always_comb begin
        // R6
        if (!in_data) begin
            nondata_free_chk: assert (!rights_fault && !use_expdn);
        end
    end
endmodule

// File: rtl/seglim_bound.sv
module seglim_bound #(
    parameter int AW = 32
) (
    input  logic [AW:0]   off_x,
    input  logic [AW:0]   end_x,
    input  logic [AW-1:0] seg_limit,
    input  logic          use_expdn,
    output logic          bound_fault
);
    logic [AW:0] lim_x;
    logic        up_fault;
    logic        dn_fault;

    assign lim_x = {1'b0, seg_limit};

    always_comb begin
        up_fault = (off_x > lim_x) || (end_x > lim_x);
        dn_fault = (off_x <= lim_x) || (end_x <= lim_x);
        bound_fault = use_expdn ? dn_fault : up_fault;
    end
endmodule

// File: rtl/seglim_checker.sv
module seglim_checker
    import seglim_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SZW  = 4,
    parameter int IDXW = 4,
    parameter int SELW = 16,
    parameter int ERRW = 16,
    parameter int DLO  = 1,
    parameter int DHI  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   lin_addr,
    input  logic [SZW-1:0]  acc_size,
    input  logic            is_write,
    input  logic            is_exec,
    input  logic [IDXW-1:0] seg_idx,
    input  logic [SELW-1:0] seg_sel,
    input  logic [AW-1:0]   seg_base,
    input  logic [AW-1:0]   seg_limit,
    input  logic            attr_wr,
    input  logic            attr_rd,
    input  logic            attr_expdn,
    input  logic            cs_dflt32,
    input  logic            cs_long,
    input  logic            lma_on,
    input  logic            asz_ovr,
    output logic            rsp_valid,
    output logic            rsp_pass,
    output logic            rsp_gp,
    output logic [ERRW-1:0] rsp_err_code
);
    seglim_state_e state_q;
    seglim_state_e state_d;
    seglim_find_t  find;

    logic          use16;
    logic          use_expdn;
    logic [AW:0]   off_x;
    logic [AW:0]   end_x;
    logic          fault;
    logic          pass_q;
    logic          gp_q;

    assign use16       = (cs_dflt32 == asz_ovr);
    assign find.bypass = lma_on && cs_long;

    seglim_offset #(.AW(AW), .SZW(SZW)) u_offset (
        .lin_addr (lin_addr),
        .seg_base (seg_base),
        .acc_size (acc_size),
        .use16    (use16),
        .off_x    (off_x),
        .end_x    (end_x)
    );

    seglim_rights #(.IDXW(IDXW), .SELW(SELW), .DLO(DLO), .DHI(DHI)) u_rights (
        .seg_idx      (seg_idx),
        .seg_sel      (seg_sel),
        .is_write     (is_write),
        .is_exec      (is_exec),
        .attr_wr      (attr_wr),
        .attr_rd      (attr_rd),
        .attr_expdn   (attr_expdn),
        .null_sel     (find.null_sel),
        .rights_fault (find.rights),
        .use_expdn    (use_expdn)
    );

    seglim_bound #(.AW(AW)) u_bound (
        .off_x       (off_x),
        .end_x       (end_x),
        .seg_limit   (seg_limit),
        .use_expdn   (use_expdn),
        .bound_fault (find.bound)
    );

    assign fault = !find.bypass && (find.null_sel || find.rights || find.bound);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            gp_q   <= 1'b0;
        end else if (req_valid) begin
            pass_q <= !fault;
            gp_q   <= fault;
        end else begin
            pass_q <= 1'b0;
            gp_q   <= 1'b0;
        end
    end

    assign rsp_valid    = (state_q == ST_RESP);
    assign rsp_pass     = pass_q;
    assign rsp_gp       = gp_q;
    assign rsp_err_code = '0;

    // R1
    req_yields_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R1
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_pass != rsp_gp));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_pass && !rsp_gp));
    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lma_on && cs_long) |=> rsp_pass);
    // R3
    null_sel_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(lma_on && cs_long) && seg_sel == '0) |=> rsp_gp);
endmodule

// File: tb/seglim_checker_tb.sv
module seglim_checker_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        lma;
        logic        csl;
        logic [3:0]  idx;
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] lim;
        logic [31:0] addr;
        logic [3:0]  size;
        logic        wr;
        logic        ex;
        logic        aw;
        logic        ar;
        logic        ed;
        logic        dflt;
        logic        ovr;
        logic        gp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    // Fields: lma csl idx sel base lim addr size wr ex aw ar ed dflt ovr exp_gp req
    localparam vec_t TBL [0:NV-1] = '{
        // R2 bypass even with zero selector and huge offset
        '{1'b1,1'b1,4'd2,16'h0000,32'h1000,32'h0,32'hFFFF0000,4'd4,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd2},
        // R2 only lma set: checks apply, null selector faults
        '{1'b1,1'b0,4'd2,16'h0000,32'h1000,32'hFF,32'h1010,4'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd2},
        // R2 only cs_long set: checks apply
        '{1'b0,1'b1,4'd2,16'h0000,32'h1000,32'hFF,32'h1010,4'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd2},
        // R3 null selector
        '{1'b0,1'b0,4'd0,16'h0000,32'h1000,32'hFF,32'h1010,4'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd3},
        // R8 inside
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1080,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd8},
        // R8 end exactly at limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h10FC,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd8},
        // R8 end one past limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h10FD,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd8},
        // R8 offset past limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1100,4'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd8},
        // R4 write to non-writable
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'd4},
        // R4 write to writable
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd4},
        // R5 read of non-readable
        '{1'b0,1'b0,4'd3,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'd5},
        // R5 fetch of non-readable
        '{1'b0,1'b0,4'd3,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5},
        // R5 write of non-readable writable
        '{1'b0,1'b0,4'd3,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5},
        // R6 index 9: writable bit ignored
        '{1'b0,1'b0,4'd9,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6},
        // R6 index 0: expand-down bit ignored
        '{1'b0,1'b0,4'd0,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd6},
        // R6 index 7: expand-up bound still enforced
        '{1'b0,1'b0,4'd7,16'h0010,32'h1000,32'hFF,32'h1200,4'd4,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,4'd6},
        // R9 expand-down above limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1200,4'd4,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd9},
        // R9 offset just above limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h1100,4'd2,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd9},
        // R9 offset equal to limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h1000,32'hFF,32'h10FF,4'd1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,4'd9},
        // R9 offset below limit
        '{1'b0,1'b0,4'd6,16'h0010,32'h1000,32'hFF,32'h1010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,4'd9},
        // R7 both clear: 16-bit, offset 0x0010
        '{1'b0,1'b0,4'd2,16'h0010,32'h0,32'hFF,32'h00010010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd7},
        // R7 both set: 16-bit
        '{1'b0,1'b0,4'd2,16'h0010,32'h0,32'hFF,32'h00010010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd7},
        // R7 default 32: 32-bit offset too large
        '{1'b0,1'b0,4'd2,16'h0010,32'h0,32'hFF,32'h00010010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd7},
        // R7 override to 32
        '{1'b0,1'b0,4'd2,16'h0010,32'h0,32'hFF,32'h00010010,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd7},
        // R7 16-bit wrap of address below base: offset 0xFFF0
        '{1'b0,1'b0,4'd2,16'h0010,32'h20,32'hFFFF,32'h10,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd7},
        // R8 16-bit end crosses 0xFFFF and is not wrapped
        '{1'b0,1'b0,4'd2,16'h0010,32'h20,32'hFFFF,32'h1E,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'd8},
        // R8 32-bit end past top of space with full limit
        '{1'b0,1'b0,4'd2,16'h0010,32'h0,32'hFFFFFFFF,32'hFFFFFFFE,4'd4,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] lin_addr = '0;
    logic [3:0]  acc_size = 4'd1;
    logic        is_write = 1'b0;
    logic        is_exec = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [15:0] seg_sel = '0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic        attr_wr = 1'b0;
    logic        attr_rd = 1'b0;
    logic        attr_expdn = 1'b0;
    logic        cs_dflt32 = 1'b0;
    logic        cs_long = 1'b0;
    logic        lma_on = 1'b0;
    logic        asz_ovr = 1'b0;
    logic        rsp_valid;
    logic        rsp_pass;
    logic        rsp_gp;
    logic [15:0] rsp_err_code;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seglim_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lin_addr(lin_addr),
        .acc_size(acc_size), .is_write(is_write), .is_exec(is_exec),
        .seg_idx(seg_idx), .seg_sel(seg_sel), .seg_base(seg_base),
        .seg_limit(seg_limit), .attr_wr(attr_wr), .attr_rd(attr_rd),
        .attr_expdn(attr_expdn), .cs_dflt32(cs_dflt32), .cs_long(cs_long),
        .lma_on(lma_on), .asz_ovr(asz_ovr), .rsp_valid(rsp_valid),
        .rsp_pass(rsp_pass), .rsp_gp(rsp_gp), .rsp_err_code(rsp_err_code)
    );

    task automatic check(input string rq, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        lma_on = v.lma;  cs_long = v.csl;   seg_idx = v.idx;   seg_sel = v.sel;
        seg_base = v.base; seg_limit = v.lim; lin_addr = v.addr; acc_size = v.size;
        is_write = v.wr; is_exec = v.ex;    attr_wr = v.aw;    attr_rd = v.ar;
        attr_expdn = v.ed; cs_dflt32 = v.dflt; asz_ovr = v.ovr;
        req_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", rsp_valid, 0, "valid in reset");
        check("R10", rsp_pass, 0, "pass in reset");
        check("R10", rsp_gp, 0, "gp in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rsp_valid, 0, "valid with no request");

        // Table walk, requests back to back
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d", TBL[i].rq), rsp_valid, 1, $sformatf("vec %0d valid", i));
            check($sformatf("R%0d", TBL[i].rq), rsp_gp, TBL[i].gp, $sformatf("vec %0d gp", i));
            check($sformatf("R%0d", TBL[i].rq), rsp_pass, !TBL[i].gp, $sformatf("vec %0d pass", i));
            if (TBL[i].gp) check("R10", rsp_err_code, 0, $sformatf("vec %0d err code", i));
        end

        // R1 response drops when requests stop
        req_valid = 1'b0;
        @(negedge clk);
        check("R1", rsp_valid, 0, "valid after last request");
        check("R1", rsp_pass, 0, "pass idle");
        check("R1", rsp_gp, 0, "gp idle");

        // R1 isolated fault then isolated pass, separated by idle
        apply(TBL[3]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", rsp_gp, 1, "isolated fault");
        @(negedge clk);
        check("R1", rsp_valid, 0, "gap after fault");
        apply(TBL[4]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", rsp_pass, 1, "isolated pass");

        // R10 reset mid-stream clears outputs
        apply(TBL[6]);
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", rsp_valid, 0, "valid after reset");
        check("R10", rsp_gp, 0, "gp after reset");
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule